// File: doc/BRIEF.md
# Page Store Address Sequencer

This block sits between a host command port and a nibble-wide DRAM page store. The host moves a cursor made of a page index, a text row and a text column, and then issues byte reads and writes at that cursor. The block turns each byte access into two nibble cycles toward a separate DRAM timing block. It produces the full nibble address, the write nibble and a per-cycle strobe. After each access it steps the cursor along the text grid.

The block also runs page-clear sweeps. One is started by a host command. Another runs on its own after reset over the first few pages. Commands arrive through a small queue, so commands issued while a transfer or sweep is running are held and then carried out in order. They are not lost.

Top module: `pgmem_seq`

## Requirements
- R1: After reset the cursor is page 0, row 0, column 0, and `busy` is high from the first cycle after reset is released. The block then sweeps pages 0 to INIT_PAGES-1 (default 8). It writes 0x20 at every in-page offset 0 to 1023, except page 0, row 0, column 7, which gets 0x07. This is 2048 write nibble cycles per page.
- R2: `mem_addr` is {page[6:0], offset[9:0], nibble}. The offset is (row*40 + column) modulo 1024. Nibble bit 1 selects the high nibble (bits 7:4) and 0 selects the low nibble (bits 3:0).
- R3: Every byte transfer uses exactly two consecutive `mem_cyc` cycles at the same byte address, high nibble first and low nibble second.
- R4: A write (op 4, byte in `cmd_arg`) drives `mem_we` high in both nibble cycles and presents the matching data nibble on `mem_wdata`. A read (op 5) drives `mem_we` low.
- R5: For a read, `rd_valid` pulses for one cycle, in the cycle after the low nibble cycle. `rd_data` is {nibble sampled in the high cycle, nibble sampled in the low cycle}.
- R6: After every read or write the column steps by one. Column 39 wraps to 0 and steps the row.
- R7: A row step from row 23 goes to row 0. Rows 24 and 25 stay where they are when the column wraps, so they can only be entered by a row load.
- R8: Op 1 loads the page from `cmd_arg[6:0]`. Op 2 loads the row and op 3 loads the column. A row value above 25 or a column value above 39 leaves the cursor unchanged. Ops 0 and 7 have no effect.
- R9: Op 6 writes 0x20 to offsets 0 to 1023 of the cursor page, in ascending order. It does not move the cursor.
- R10: Commands are pushed while `cmd_valid` is high. They are queued FIFO_DEPTH deep (default 4) and executed in arrival order. `cmd_ready` is low while the queue is full, and a push in that cycle is discarded.
- R11: `busy` is high while a nibble transfer or a sweep is running and low otherwise. A cursor load uses one idle cycle and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Push a command this cycle |
| cmd_op | input | 3 | Command code (see R8, R4, R5, R9) |
| cmd_arg | input | 8 | Command argument or write byte |
| cmd_ready | output | 1 | Queue has space |
| busy | output | 1 | Transfer or sweep in progress |
| mem_cyc | output | 1 | Nibble memory cycle strobe |
| mem_we | output | 1 | Nibble cycle is a write |
| mem_addr | output | 18 | Page, in-page offset, nibble select |
| mem_wdata | output | 4 | Write nibble |
| mem_rdata | input | 4 | Read nibble, sampled at the end of the cycle |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Assembled read byte |

## Verification
The bench targets the cursor wrap points:
- Column 39 into the next row.
- Row 23 back to row 0. A design that let the increment run on would write into row 24.
- A write at row 24, column 39. A design that kept rows 24 and 25 inside the loop would move on to row 25 or row 0.
- Row 25, column 30, whose offset folds to 6. A design without the modulo would reach into the next page.

It checks the lone 0x07 byte left by the start-up sweep and the exact number of sweep writes. A short or off-by-one sweep shows up as a wrong count or a stale byte at row 25, column 23. It checks that a clear leaves the cursor where it was. It also floods the queue: a design that dropped queued commands, or accepted pushes while full, would execute a different number of writes than were accepted.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;

    localparam int PAGE_W = 7;
    localparam int OFF_W  = 10;
    localparam int ROW_W  = 5;
    localparam int COL_W  = 6;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    localparam int ROWS      = 26;
    localparam int LOOP_ROWS = 24;
    localparam int COLS      = 40;

    localparam int ADDR_W = PAGE_W + OFF_W + 1;
    localparam int FULL_W = OFF_W + 1;

    localparam logic [BYTE_W-1:0] CLR_CODE  = 8'h20;
    localparam logic [BYTE_W-1:0] MARK_CODE = 8'h07;
    localparam logic [OFF_W-1:0]  MARK_OFF  = OFF_W'(7);
    localparam logic [OFF_W-1:0]  OFF_LAST  = {OFF_W{1'b1}};

    localparam logic [BYTE_W-1:0] ROW_MAX_ARG = BYTE_W'(ROWS - 1);
    localparam logic [BYTE_W-1:0] COL_MAX_ARG = BYTE_W'(COLS - 1);
    localparam logic [ROW_W-1:0]  ROW_LOOP_END = ROW_W'(LOOP_ROWS - 1);
    localparam logic [COL_W-1:0]  COL_END      = COL_W'(COLS - 1);

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PAGE  = 3'd1,
        OP_ROW   = 3'd2,
        OP_COL   = 3'd3,
        OP_WRITE = 3'd4,
        OP_READ  = 3'd5,
        OP_CLEAR = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [BYTE_W-1:0] arg;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_START,
        ST_IDLE,
        ST_HI,
        ST_LO
    } st_e;

    typedef enum logic [1:0] {
        K_WR,
        K_RD,
        K_CLR
    } kind_e;

    typedef logic [FULL_W-1:0] full_t;

    function automatic logic [OFF_W-1:0] grid_offset(
        input logic [ROW_W-1:0] row,
        input logic [COL_W-1:0] col
    );
        full_t lin;
        lin = full_t'(row) * full_t'(COLS) + full_t'(col);
        return lin[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/pgmem_fifo.sv
module pgmem_fifo #(
    parameter int WIDTH = 11,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (count == CNT_FULL);
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pgmem_cursor.sv
module pgmem_cursor
    import pgmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_page,
    input  logic              ld_row,
    input  logic              ld_col,
    input  logic [BYTE_W-1:0] ld_val,
    input  logic              step,
    output logic [PAGE_W-1:0] page_o,
    output logic [OFF_W-1:0]  offset_o
);
    logic [PAGE_W-1:0] page_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              row_ok;
    logic              col_ok;

    assign row_ok   = (ld_val <= ROW_MAX_ARG);
    assign col_ok   = (ld_val <= COL_MAX_ARG);
    assign page_o   = page_q;
    assign offset_o = grid_offset(row_q, col_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
        end else if (step) begin
            if (col_q == COL_END) begin
                col_q <= '0;
                if (row_q == ROW_LOOP_END) begin
                    row_q <= '0;
                end else if (row_q < ROW_LOOP_END) begin
                    row_q <= row_q + 1'b1;
                end
            end else begin
                col_q <= col_q + 1'b1;
            end
        end else begin
            if (ld_page) begin
                page_q <= ld_val[PAGE_W-1:0];
            end
            if (ld_row && row_ok) begin
                row_q <= ld_val[ROW_W-1:0];
            end
            if (ld_col && col_ok) begin
                col_q <= ld_val[COL_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pgmem_engine.sv
module pgmem_engine
    import pgmem_pkg::*;
#(
    parameter int INIT_PAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              head,
    input  logic              q_empty,
    output logic              q_pop,
    input  logic [PAGE_W-1:0] cur_page,
    input  logic [OFF_W-1:0]  cur_off,
    output logic              ld_page,
    output logic              ld_row,
    output logic              ld_col,
    output logic [BYTE_W-1:0] ld_val,
    output logic              step,
    output logic              busy,
    output logic              mem_cyc,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NIB_W-1:0]  mem_wdata,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);
    localparam logic [PAGE_W-1:0] INIT_LAST = PAGE_W'(INIT_PAGES - 1);
    localparam logic [PAGE_W-1:0] MARK_PAGE = '0;

    st_e               st;
    kind_e             kind;
    logic              init_q;
    logic [PAGE_W-1:0] xpage;
    logic [OFF_W-1:0]  xoff;
    logic [BYTE_W-1:0] xbyte;
    logic [NIB_W-1:0]  rd_hi;
    logic              nib_hi;
    logic              mark_hit;
    logic [BYTE_W-1:0] out_byte;

    assign q_pop   = (st == ST_IDLE) && !q_empty;
    assign ld_page = q_pop && (head.op == OP_PAGE);
    assign ld_row  = q_pop && (head.op == OP_ROW);
    assign ld_col  = q_pop && (head.op == OP_COL);
    assign ld_val  = head.arg;
    assign step    = (st == ST_LO) && (kind != K_CLR);

    assign busy     = (st != ST_IDLE);
    assign mem_cyc  = (st == ST_HI) || (st == ST_LO);
    assign nib_hi   = (st == ST_HI);
    assign mem_we   = mem_cyc && (kind != K_RD);
    assign mem_addr = {xpage, xoff, nib_hi};

    assign mark_hit = init_q && (xpage == MARK_PAGE) && (xoff == MARK_OFF);
    always_comb begin
        if (kind == K_CLR) begin
            out_byte = mark_hit ? MARK_CODE : CLR_CODE;
        end else begin
            out_byte = xbyte;
        end
    end
    assign mem_wdata = nib_hi ? out_byte[BYTE_W-1:NIB_W] : out_byte[NIB_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_START;
            kind     <= K_CLR;
            init_q   <= 1'b1;
            xpage    <= '0;
            xoff     <= '0;
            xbyte    <= '0;
            rd_hi    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (st)
                ST_START: begin
                    kind <= K_CLR;
                    st   <= ST_HI;
                end
                ST_IDLE: begin
                    if (!q_empty) begin
                        unique case (head.op)
                            OP_WRITE: begin
                                xpage <= cur_page;
                                xoff  <= cur_off;
                                xbyte <= head.arg;
                                kind  <= K_WR;
                                st    <= ST_HI;
                            end
                            OP_READ: begin
                                xpage <= cur_page;
                                xoff  <= cur_off;
                                kind  <= K_RD;
                                st    <= ST_HI;
                            end
                            OP_CLEAR: begin
                                xpage <= cur_page;
                                xoff  <= '0;
                                kind  <= K_CLR;
                                st    <= ST_HI;
                            end
                            default: begin
                                st <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_HI: begin
                    if (kind == K_RD) begin
                        rd_hi <= mem_rdata;
                    end
                    st <= ST_LO;
                end
                ST_LO: begin
                    if (kind == K_CLR) begin
                        if (xoff == OFF_LAST) begin
                            if (init_q && (xpage != INIT_LAST)) begin
                                xpage <= xpage + 1'b1;
                                xoff  <= '0;
                                st    <= ST_HI;
                            end else begin
                                init_q <= 1'b0;
                                st     <= ST_IDLE;
                            end
                        end else begin
                            xoff <= xoff + 1'b1;
                            st   <= ST_HI;
                        end
                    end else begin
                        if (kind == K_RD) begin
                            rd_valid <= 1'b1;
                            rd_data  <= {rd_hi, mem_rdata};
                        end
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgmem_seq.sv
module pgmem_seq
    import pgmem_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int INIT_PAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_arg,
    output logic              cmd_ready,
    output logic              busy,
    output logic              mem_cyc,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NIB_W-1:0]  mem_wdata,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int CMD_W = $bits(cmd_t);

    cmd_t              cmd_in;
    logic [CMD_W-1:0]  q_dout;
    cmd_t              q_head;
    logic              q_full;
    logic              q_empty;
    logic              q_pop;
    logic [PAGE_W-1:0] cur_page;
    logic [OFF_W-1:0]  cur_off;
    logic              ld_page;
    logic              ld_row;
    logic              ld_col;
    logic [BYTE_W-1:0] ld_val;
    logic              step;

    assign cmd_in.op  = op_e'(cmd_op);
    assign cmd_in.arg = cmd_arg;
    assign q_head     = cmd_t'(q_dout);
    assign cmd_ready  = !q_full;

    pgmem_fifo #(
        .WIDTH (CMD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (cmd_valid),
        .din   (cmd_in),
        .pop   (q_pop),
        .dout  (q_dout),
        .full  (q_full),
        .empty (q_empty)
    );

    pgmem_cursor u_cursor (
        .clk      (clk),
        .rst      (rst),
        .ld_page  (ld_page),
        .ld_row   (ld_row),
        .ld_col   (ld_col),
        .ld_val   (ld_val),
        .step     (step),
        .page_o   (cur_page),
        .offset_o (cur_off)
    );

    pgmem_engine #(
        .INIT_PAGES (INIT_PAGES)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .head      (q_head),
        .q_empty   (q_empty),
        .q_pop     (q_pop),
        .cur_page  (cur_page),
        .cur_off   (cur_off),
        .ld_page   (ld_page),
        .ld_row    (ld_row),
        .ld_col    (ld_col),
        .ld_val    (ld_val),
        .step      (step),
        .busy      (busy),
        .mem_cyc   (mem_cyc),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/pgmem_seq_chk.sv
module pgmem_seq_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              mem_cyc,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_valid
);
    // R3: a high-nibble cycle is followed by the low nibble of the same byte
    p_pair_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_cyc && mem_addr[0]) |=> (mem_cyc && !mem_addr[0]
            && (mem_addr[ADDR_W-1:1] == $past(mem_addr[ADDR_W-1:1]))
            && (mem_we == $past(mem_we))));

    // R3: a low-nibble cycle always comes right after a high-nibble cycle
    p_hi_first_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_cyc && !mem_addr[0]) |-> $past(mem_cyc && mem_addr[0]));

    // R5: read data appears only after the low nibble of a read
    p_rd_after_lo_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(mem_cyc && !mem_we && !mem_addr[0]));

    // R5: read valid is a single-cycle pulse
    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R11: no memory cycle without busy
    p_cyc_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_cyc |-> busy);

    // R1: the start-up sweep holds busy from the first cycle after reset
    p_init_busy_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> busy);
endmodule

bind pgmem_seq pgmem_seq_chk #(.ADDR_W(pgmem_pkg::ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .mem_cyc  (mem_cyc),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .rd_valid (rd_valid)
);

// File: tb/sim_pgmem_seq.sv
module sim_pgmem_seq;
    localparam int DEPTH = 4;
    localparam int NINIT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_arg = 8'd0;
    logic       cmd_ready, busy, mem_cyc, mem_we, rd_valid;
    logic [17:0] mem_addr;
    logic [3:0] mem_wdata;
    logic [3:0] mem_rdata = 4'd0;
    logic [7:0] rd_data;

    always #2 clk = ~clk;

    pgmem_seq #(.FIFO_DEPTH(DEPTH), .INIT_PAGES(NINIT)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_ready(cmd_ready), .busy(busy),
        .mem_cyc(mem_cyc), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    int acc_cnt = 0;
    int saw_full = 0;
    int wr_nib = 0;
    int rdq[$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 start, 1 idle, 2 high nibble, 3 low nibble
    // kind: 0 write, 1 read, 2 clear
    int ms, mkind, minit, mpage, mrow, mcol, xpage, xoff, xbyte, mrdv, mrdd;
    int mq[$];
    int mmem [int];
    int c, op, a, acc, key;

    function automatic int clr_byte();
        return (minit != 0 && xpage == 0 && xoff == 7) ? 8'h07 : 8'h20;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ms = 0; mkind = 2; minit = 1; mpage = 0; mrow = 0; mcol = 0;
            xpage = 0; xoff = 0; xbyte = 0; mrdv = 0;
            mq.delete();
        end else begin
            acc = (cmd_valid && mq.size() < DEPTH) ? 1 : 0;
            mrdv = 0;
            case (ms)
                0: begin ms = 2; mkind = 2; end
                1: if (mq.size() > 0) begin
                    c = mq.pop_front();
                    op = c / 256;
                    a = c % 256;
                    case (op)
                        1: mpage = a % 128;
                        2: if (a <= 25) mrow = a;
                        3: if (a <= 39) mcol = a;
                        4: begin xpage = mpage; xoff = (mrow * 40 + mcol) % 1024;
                                 xbyte = a; mkind = 0; ms = 2; end
                        5: begin xpage = mpage; xoff = (mrow * 40 + mcol) % 1024;
                                 mkind = 1; ms = 2; end
                        6: begin xpage = mpage; xoff = 0; mkind = 2; ms = 2; end
                        default: ;
                    endcase
                end
                2: ms = 3;
                default: begin
                    key = xpage * 1024 + xoff;
                    if (mkind == 2) begin
                        mmem[key] = clr_byte();
                        if (xoff == 1023) begin
                            if (minit != 0 && xpage != NINIT - 1) begin
                                xpage++; xoff = 0; ms = 2;
                            end else begin
                                minit = 0; ms = 1;
                            end
                        end else begin
                            xoff++; ms = 2;
                        end
                    end else begin
                        if (mkind == 0) mmem[key] = xbyte;
                        else begin
                            mrdv = 1;
                            mrdd = mmem.exists(key) ? mmem[key] : 0;
                        end
                        if (mcol == 39) begin
                            mcol = 0;
                            if (mrow == 23) mrow = 0;
                            else if (mrow < 23) mrow++;
                        end else mcol++;
                        ms = 1;
                    end
                end
            endcase
            if (acc != 0) mq.push_back(int'(cmd_op) * 256 + int'(cmd_arg));
        end
    end

    // DRAM stand-in and per-cycle comparison, away from the active edge
    logic [3:0] dram [int];
    int eb, ecyc, ehi;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_cyc && mem_we) begin
                dram[int'(mem_addr)] = mem_wdata;
                wr_nib++;
            end
            mem_rdata = dram.exists(int'(mem_addr)) ? dram[int'(mem_addr)] : 4'h0;
            if (rd_valid) rdq.push_back(int'(rd_data));

            eb   = (mkind == 2) ? clr_byte() : xbyte;
            ecyc = (ms == 2 || ms == 3) ? 1 : 0;
            ehi  = (ms == 2) ? 1 : 0;
            chk("R3 mem_cyc", int'(mem_cyc), ecyc);
            chk("R11 busy", int'(busy), (ms != 1) ? 1 : 0);
            chk("R10 cmd_ready", int'(cmd_ready), (mq.size() < DEPTH) ? 1 : 0);
            chk("R5 rd_valid", int'(rd_valid), mrdv);
            if (mrdv != 0) chk("R5 rd_data", int'(rd_data), mrdd);
            if (ecyc != 0) begin
                chk("R2 mem_addr", int'(mem_addr), xpage * 2048 + xoff * 2 + ehi);
                chk("R4 mem_we", int'(mem_we), (mkind != 1) ? 1 : 0);
                if (mkind != 1)
                    chk("R4 mem_wdata", int'(mem_wdata), (ehi != 0) ? (eb / 16) : (eb % 16));
            end
        end
    end

    // driver helpers, called at a falling edge
    task automatic send(input int o, input int v);
        cmd_valid = 1'b1;
        cmd_op = 3'(o);
        cmd_arg = 8'(v);
        if (cmd_ready) acc_cnt++;
        else saw_full = 1;
        @(negedge clk);
    endtask

    task automatic stop();
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || mq.size() != 0);
        @(negedge clk);
    endtask

    task automatic read_at(input int p, input int r, input int cl, output int v);
        send(1, p); send(2, r); send(3, cl); send(5, 0);
        stop();
        wait_idle();
        v = (rdq.size() > 0) ? rdq.pop_front() : -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, w0, acc0;
        repeat (4) @(negedge clk);
        chk("R1 reset mem_cyc", int'(mem_cyc), 0);
        chk("R1 reset rd_valid", int'(rd_valid), 0);
        chk("R1 reset cmd_ready", int'(cmd_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 1);
        wait_idle();
        chk("R1 start-up sweep write nibbles", wr_nib, NINIT * 2048);

        // R1 cursor at page 0 row 0 col 0 after reset
        send(4, 8'hC3); stop(); wait_idle();
        read_at(0, 0, 0, v); chk("R1 cursor home write", v, 8'hC3);
        read_at(0, 0, 7, v); chk("R1 mark byte", v, 8'h07);
        read_at(0, 0, 8, v); chk("R1 cleared byte", v, 8'h20);
        read_at(7, 25, 23, v); chk("R1 last init page end", v, 8'h20);
        read_at(8, 0, 0, v); chk("R1 page beyond init untouched", v, 8'h00);

        // R6 column wrap into next row, page load masked to 7 bits (R8)
        send(1, 8'h85); send(2, 3); send(3, 38);
        send(4, 8'hA5); send(4, 8'h3C); send(4, 8'h99); stop(); wait_idle();
        read_at(5, 3, 38, v); chk("R8 page arg masked", v, 8'hA5);
        read_at(5, 3, 39, v); chk("R6 col 39", v, 8'h3C);
        send(5, 0); stop(); wait_idle();
        v = (rdq.size() > 0) ? rdq.pop_front() : -1;
        chk("R6 read step wraps to next row", v, 8'h99);

        // R7 row 23 wraps to 0; row 24 stays put
        send(1, 12); send(2, 23); send(3, 39);
        send(4, 8'h5A); send(4, 8'h6B); stop(); wait_idle();
        read_at(12, 0, 0, v); chk("R7 row 23 wraps to row 0", v, 8'h6B);
        send(1, 12); send(2, 24); send(3, 39);
        send(4, 8'h71); send(4, 8'h72); stop(); wait_idle();
        read_at(12, 24, 0, v); chk("R7 row 24 holds on wrap", v, 8'h72);
        read_at(12, 25, 0, v); chk("R7 row 25 untouched", v, 8'h00);

        // R2 offset folds modulo 1024
        send(1, 12); send(2, 25); send(3, 30); send(4, 8'hE1); stop(); wait_idle();
        read_at(12, 0, 6, v); chk("R2 offset modulo 1024", v, 8'hE1);

        // R8 out-of-range loads and reserved ops have no effect
        send(1, 12); send(2, 2); send(3, 5);
        send(2, 26); send(3, 40); send(7, 8'h11); send(0, 8'h22);
        send(4, 8'h44); stop(); wait_idle();
        read_at(12, 2, 5, v); chk("R8 ignored loads keep cursor", v, 8'h44);

        // R11 a load alone does not raise busy
        send(1, 3); stop();
        repeat (3) begin
            chk("R11 load keeps busy low", int'(busy), 0);
            @(negedge clk);
        end

        // R9 clear sweep keeps the cursor
        send(1, 12); send(2, 10); send(3, 10);
        w0 = wr_nib;
        send(6, 0); send(4, 8'h55); stop(); wait_idle();
        chk("R9 clear write nibbles", wr_nib - w0, 2048 + 2);
        read_at(12, 10, 10, v); chk("R9 cursor unchanged by clear", v, 8'h55);
        read_at(12, 24, 0, v); chk("R9 row 24 cleared", v, 8'h20);
        read_at(12, 25, 23, v); chk("R9 sweep end cleared", v, 8'h20);
        read_at(12, 0, 6, v); chk("R9 folded offset cleared", v, 8'h20);

        // R10 flood the queue
        send(1, 20); send(2, 0); send(3, 0); stop(); wait_idle();
        acc0 = acc_cnt; saw_full = 0; w0 = wr_nib;
        for (int i = 0; i < 10; i++) send(4, 8'h30 + i);
        stop(); wait_idle();
        chk("R10 queue reported full", saw_full, 1);
        chk("R10 executed equals accepted", (wr_nib - w0) / 2, acc_cnt - acc0);
        chk("R10 some pushes refused", ((acc_cnt - acc0) < 10) ? 1 : 0, 1);
        read_at(20, 0, 0, v); chk("R10 first queued write in order", v, 8'h30);
        read_at(20, 0, 1, v); chk("R10 second queued write in order", v, 8'h31);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule